// File: doc/BRIEF.md
# Raster Coordinate Stepper

The block produces the pixel coordinates of a raster scan, for correlation and tracking pipelines that need to know where they are in an image. A column counter `col_o` runs from 0 up to a row length minus one and then wraps to 0. A row counter `row_o` rises by one on every wrap. A `done_o` flag reports that the row counter has reached a limit. The row length and the row limit are runtime inputs. They are captured when a start command arrives.

Loop control is not a branch. It is three register updates that run side by side in the same cycle: column, row and completion. Each one chooses its next value by data selection. The column and row registers each keep their own copy of the wrap test. A build-time parameter picks one of two variants. The first compares values combinationally. The second keeps the wrap test and the row-limit test in registers that look one step ahead. At the ports, both variants behave cycle for cycle the same.

Top module: `raster_coord_gen`

## Requirements
- R1: After synchronous reset, `col_o` = 0, `row_o` = 0 and `done_o` = 0. The captured row length and row limit are both 0.
- R2: When `start_i` is high at a clock edge, the next cycle shows `col_o` = 0, `row_o` = 0 and `done_o` = 0. At that edge `len_i` and `lim_i` are captured as the row length L and the row limit N.
- R3: If `start_i` and `adv_i` are high in the same cycle, the start wins and no step is taken.
- R4: A step is an edge where `adv_i` is high, `start_i` is low and `done_o` is low. On a step, `col_o` becomes 0 if (`col_o`+1) mod 4096 equals L. Otherwise `col_o` becomes `col_o`+1.
- R5: On a step, `row_o` rises by one (mod 4096) under that same wrap condition. Otherwise it keeps its value.
- R6: On a step, `done_o` takes the value (`row_o` == N), where `row_o` is its value before that step.
- R7: When neither `start_i` nor `adv_i` is high, `col_o`, `row_o` and `done_o` keep their values.
- R8: While `done_o` is high, `adv_i` has no effect. `col_o`, `row_o` and `done_o` are held until the next start.
- R9: Changes on `len_i` and `lim_i` between starts have no effect on the sequence.
- R10: With `LOOKAHEAD` = 1, the outputs match the combinational variant on every cycle for the same inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Clear counters and capture the limits |
| adv_i | input | 1 | Step enable |
| len_i | input | 12 | Row length L, captured at start |
| lim_i | input | 12 | Row limit N, captured at start |
| col_o | output | 12 | Column coordinate |
| row_o | output | 12 | Row coordinate |
| done_o | output | 1 | Row limit reached |

## Verification
The assertions assume only that the control inputs are known after reset. They make no assumption about the limits, because the limits are read only at a start. The stimulus draws row lengths from 1 to 6 and row limits from 0 to 4, so wraps and completions happen often. It changes the limit inputs freely between starts. It also issues starts at random, sometimes in the same cycle as a step, which covers the start priority and the restart after completion.

// File: rtl/coord_pkg.sv
package coord_pkg;
    localparam int unsigned COORD_W = 12;

    typedef logic [COORD_W-1:0] coord_t;

    typedef struct packed {
        coord_t len;
        coord_t lim;
    } scan_lim_t;

    // true when (v + off) modulo 2**COORD_W equals target
    function automatic logic hits(coord_t v, coord_t target, coord_t off);
        coord_t s;
        s = v + off;
        return s == target;
    endfunction
endpackage

// File: rtl/coord_col_path.sv
module coord_col_path
    import coord_pkg::*;
#(
    parameter bit LOOKAHEAD = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   step,
    input  coord_t len_new,
    input  coord_t len_held,
    output coord_t col
);
    localparam coord_t ONE = coord_t'(1);
    localparam coord_t TWO = coord_t'(2);

    coord_t col_q;
    logic   wrap;

    generate
        if (LOOKAHEAD) begin : g_ahead
            logic wrap_q;
            always_ff @(posedge clk) begin
                if (rst)
                    wrap_q <= 1'b0;
                else if (start)
                    wrap_q <= hits('0, len_new, ONE);
                else if (step)
                    wrap_q <= wrap_q ? hits('0, len_held, ONE)
                                     : hits(col_q, len_held, TWO);
            end
            assign wrap = wrap_q;
        end else begin : g_comb
            assign wrap = hits(col_q, len_held, ONE);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || start)
            col_q <= '0;
        else if (step)
            col_q <= wrap ? '0 : col_q + ONE;
    end

    assign col = col_q;
endmodule

// File: rtl/coord_row_path.sv
module coord_row_path
    import coord_pkg::*;
#(
    parameter bit LOOKAHEAD = 1'b0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   step,
    input  coord_t col,
    input  scan_lim_t lim_new,
    input  scan_lim_t lim_held,
    output coord_t row,
    output logic   row_at_lim
);
    localparam coord_t ONE = coord_t'(1);
    localparam coord_t TWO = coord_t'(2);

    coord_t row_q;
    logic   wrap;

    generate
        if (LOOKAHEAD) begin : g_ahead
            logic wrap_q;
            logic at_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    wrap_q <= 1'b0;
                    at_q   <= 1'b1;
                end else if (start) begin
                    wrap_q <= hits('0, lim_new.len, ONE);
                    at_q   <= (lim_new.lim == '0);
                end else if (step) begin
                    wrap_q <= wrap_q ? hits('0, lim_held.len, ONE)
                                     : hits(col, lim_held.len, TWO);
                    if (wrap_q)
                        at_q <= hits(row_q, lim_held.lim, ONE);
                end
            end
            assign wrap       = wrap_q;
            assign row_at_lim = at_q;
        end else begin : g_comb
            assign wrap       = hits(col, lim_held.len, ONE);
            assign row_at_lim = (row_q == lim_held.lim);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || start)
            row_q <= '0;
        else if (step && wrap)
            row_q <= row_q + ONE;
    end

    assign row = row_q;
endmodule

// File: rtl/coord_done_path.sv
module coord_done_path (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic step,
    input  logic row_at_lim,
    output logic done
);
    always_ff @(posedge clk) begin
        if (rst || start)
            done <= 1'b0;
        else if (step)
            done <= row_at_lim;
    end
endmodule

// File: rtl/raster_coord_gen.sv
module raster_coord_gen
    import coord_pkg::*;
#(
    parameter bit LOOKAHEAD = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                adv_i,
    input  logic [COORD_W-1:0]  len_i,
    input  logic [COORD_W-1:0]  lim_i,
    output logic [COORD_W-1:0]  col_o,
    output logic [COORD_W-1:0]  row_o,
    output logic                done_o
);
    scan_lim_t lim_new;
    scan_lim_t lim_q;
    logic      step;
    logic      row_at_lim;
    coord_t    col;
    coord_t    row;
    logic      done;

    assign lim_new.len = len_i;
    assign lim_new.lim = lim_i;

    always_ff @(posedge clk) begin
        if (rst)
            lim_q <= '0;
        else if (start_i)
            lim_q <= lim_new;
    end

    assign step = adv_i & ~start_i & ~done;

    coord_col_path #(.LOOKAHEAD(LOOKAHEAD)) u_col (
        .clk      (clk),
        .rst      (rst),
        .start    (start_i),
        .step     (step),
        .len_new  (lim_new.len),
        .len_held (lim_q.len),
        .col      (col)
    );

    coord_row_path #(.LOOKAHEAD(LOOKAHEAD)) u_row (
        .clk        (clk),
        .rst        (rst),
        .start      (start_i),
        .step       (step),
        .col        (col),
        .lim_new    (lim_new),
        .lim_held   (lim_q),
        .row        (row),
        .row_at_lim (row_at_lim)
    );

    coord_done_path u_done (
        .clk        (clk),
        .rst        (rst),
        .start      (start_i),
        .step       (step),
        .row_at_lim (row_at_lim),
        .done       (done)
    );

    assign col_o  = col;
    assign row_o  = row;
    assign done_o = done;
endmodule

// File: rtl/raster_coord_chk.sv
module raster_coord_chk
    import coord_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   start_i,
    input logic   adv_i,
    input coord_t col_o,
    input coord_t row_o,
    input logic   done_o
);
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (col_o == '0) && (row_o == '0) && !done_o); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !adv_i) |=> $stable(col_o) && $stable(row_o) && $stable(done_o)); // R7

    AST_DONE_FREEZES: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> $stable(col_o) && $stable(row_o) && done_o); // R8

    AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !start_i && !done_o) |=>
            (col_o == '0) || (col_o == coord_t'($past(col_o) + coord_t'(1)))); // R4

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !start_i && !done_o) |=>
            (row_o == $past(row_o)) ||
            ((row_o == coord_t'($past(row_o) + coord_t'(1))) && (col_o == '0))); // R5

    AST_DONE_ON_STEP: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(adv_i) && !$past(start_i)); // R6
endmodule

bind raster_coord_gen raster_coord_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .adv_i   (adv_i),
    .col_o   (col_o),
    .row_o   (row_o),
    .done_o  (done_o)
);

// File: tb/tb_raster_coord_gen.sv
module tb_raster_coord_gen;
    localparam int CLK_PERIOD = 10;
    localparam int W = 12;

    logic clk = 1'b0;
    logic rst;
    logic start_i, adv_i;
    logic [W-1:0] len_i, lim_i;
    logic [W-1:0] col_o, row_o, col_p, row_p;
    logic done_o, done_p;

    int n_vec = 0;
    int n_bad = 0;

    // bench model state
    logic [W-1:0] mx, my, hl, hn;
    logic md;
    string last_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    raster_coord_gen #(.LOOKAHEAD(1'b0)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .adv_i(adv_i),
        .len_i(len_i), .lim_i(lim_i),
        .col_o(col_o), .row_o(row_o), .done_o(done_o));

    raster_coord_gen #(.LOOKAHEAD(1'b1)) dut_ahead (
        .clk(clk), .rst(rst), .start_i(start_i), .adv_i(adv_i),
        .len_i(len_i), .lim_i(lim_i),
        .col_o(col_p), .row_o(row_p), .done_o(done_p));

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // compare both instances against the model, just before the next drive
    task automatic compare_all();
        string t;
        t = last_tag;
        check({t, "(col)"},  col_o, mx);
        check({t, "(row)"},  row_o, my);
        check({t, "(done)"}, W'(done_o), W'(md));
        check("R10(col)",  col_p, col_o);
        check("R10(row)",  row_p, row_o);
        check("R10(done)", W'(done_p), W'(done_o));
    endtask

    // drive one cycle: set inputs at negedge, advance the model, wait, compare
    task automatic cycle(input logic s, input logic a, input logic [W-1:0] l, input logic [W-1:0] n);
        logic wr, nd;
        start_i = s; adv_i = a; len_i = l; lim_i = n;
        if (s) begin
            mx = '0; my = '0; md = 1'b0; hl = l; hn = n;
            last_tag = a ? "R3" : "R2";
        end else if (a && !md) begin
            wr = (W'(mx + 1'b1) == hl);
            nd = (my == hn);
            mx = wr ? '0 : W'(mx + 1'b1);
            my = wr ? W'(my + 1'b1) : my;
            md = nd;
            last_tag = "R4R5R6";
        end else if (a) begin
            last_tag = "R8";
        end else begin
            last_tag = "R7";
        end
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; start_i = 1'b0; adv_i = 1'b0; len_i = '0; lim_i = '0;
        mx = '0; my = '0; md = 1'b0; hl = '0; hn = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        last_tag = "R1";
        compare_all();

        // R3: start together with a step, then a 3x2 scan to completion
        cycle(1'b1, 1'b1, 12'd3, 12'd2);
        for (int i = 0; i < 12; i++) cycle(1'b0, 1'b1, 12'd3, 12'd2);
        // R8: stepping while done changes nothing
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1, 12'd9, 12'd9);

        // R9: limits change after the start and must be ignored
        cycle(1'b1, 1'b0, 12'd2, 12'd1);
        for (int i = 0; i < 8; i++) cycle(1'b0, 1'b1, 12'd5, 12'd7);
        // R4 corner: row length 1 makes every step a wrap
        cycle(1'b1, 1'b0, 12'd1, 12'd3);
        for (int i = 0; i < 6; i++) cycle(1'b0, 1'b1, 12'd1, 12'd3);
        // R6 corner: limit 0 finishes on the first step
        cycle(1'b1, 1'b0, 12'd4, 12'd0);
        cycle(1'b0, 1'b1, 12'd4, 12'd0);
        cycle(1'b0, 1'b0, 12'd4, 12'd0);

        for (int i = 0; i < 4000; i++) begin
            logic s, a;
            s = ($urandom % 14) == 0;
            a = ($urandom % 10) < 7;
            cycle(s, a, W'(1 + $urandom % 6), W'($urandom % 5));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule